// File: doc/BRIEF.md
# Backlight PWM Dimming Controller

This block produces the brightness PWM that feeds an external LED backlight driver. A requested brightness in percent (0 to 100) and a period length in system-clock cycles set a low-rate PWM, typically tuned to a few hundred hertz to follow 50 Hz or 60 Hz video. A wider on-time gives a brighter backlight, and a request of 100 holds the output fully on.

The driver needs time to settle after it is switched on. While a settling window of half a second (a parameter) runs after driver enable, the controller will not let the on-time fall below 5 %. Once the window has passed, the floor drops to 1 % and a flag reports that the low range is open. Dropping the enable forces the output low, clears the flag and rearms the window. Duty and period are taken only at a period boundary, so a change never cuts a pulse short or adds a runt pulse.

Top module: `bl_dim_ctrl`

## Requirements
- R1: While rst_ni is low or drv_en_i is low, pwm_o is low.
- R2: In each period of P cycles with effective duty D percent, pwm_o is high for exactly floor(D*P/100) cycles, in the first cycles of the period. The first period begins on the first clock edge that samples drv_en_i high. D = 100 keeps pwm_o high for the whole period.
- R3: low_unlock_o rises after exactly SETTLE_CYC consecutive clock edges that sample drv_en_i high, where SETTLE_CYC = CLK_HZ/1000*SETTLE_MS. It then stays high while drv_en_i stays high.
- R4: While low_unlock_o is low, a request below 5 is raised to 5. Once it is high, a request below 1 (that is, 0) is raised to 1. The floor in force at a period's first edge applies to that whole period.
- R5: When drv_en_i goes low, pwm_o and low_unlock_o go low in the same cycle, with no clock edge needed. The next enable restarts the settling window from zero, with the 5 % floor.
- R6: A change to duty_req_i takes effect only at the next period boundary. The period in progress keeps its high time.
- R7: period_i is sampled at each period boundary, and a change takes effect at the next boundary. A value of 0 is treated as 1.
- R8: A duty_req_i value above 100 is treated as 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_en_i | input | 1 | Backlight driver on; the PWM runs only while it is high |
| duty_req_i | input | 7 | Requested brightness in percent, 0 to 100 (larger values saturate) |
| period_i | input | PERIOD_W | PWM period in clock cycles |
| pwm_o | output | 1 | Brightness PWM, high = LED on |
| low_unlock_o | output | 1 | High once the settling window has passed and the 1 % floor applies |

## Verification
The bench builds the block with CLK_HZ = 2000 and SETTLE_MS = 500, which gives a settling window of 1000 cycles. This makes the exact rising edge of the unlock flag, and the switch from the 5 % floor to the 1 % floor at the next period boundary, reachable in about a thousand cycles. PERIOD_W is 16, so periods from 10 to 200 cycles give distinct rounding cases, such as 33 % of 10 cycles giving 3 high cycles. Mid-period changes of duty and period and a mid-pulse drop of enable are placed on exact cycles, so each boundary rule is checked on its own.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;

    localparam int unsigned PCT_W     = 7;
    localparam int unsigned PCT_FULL  = 100;
    localparam int unsigned FLOOR_NEW = 5;
    localparam int unsigned FLOOR_OLD = 1;

    typedef logic [PCT_W-1:0] pct_t;

endpackage

// File: rtl/bl_settle_timer.sv
module bl_settle_timer #(
    parameter int unsigned SETTLE_CYC = 1000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic open_o
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             open;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt  = '0;
            st_d.open = 1'b0;
        end else if (!st_q.open) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;

endmodule

// File: rtl/bl_duty_clamp.sv
module bl_duty_clamp
    import bl_dim_pkg::*;
(
    input  pct_t req_i,
    input  logic open_i,
    output pct_t eff_o
);
    pct_t sat;
    pct_t floor_v;

    always_comb begin
        sat     = (req_i > pct_t'(PCT_FULL)) ? pct_t'(PCT_FULL) : req_i;
        floor_v = open_i ? pct_t'(FLOOR_OLD) : pct_t'(FLOOR_NEW);
        eff_o   = (sat < floor_v) ? floor_v : sat;
    end

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_dim_pkg::*;
#(
    parameter int unsigned PERIOD_W = 24
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                en_i,
    input  pct_t                duty_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                pwm_o
);
    localparam int unsigned PROD_W = PERIOD_W + PCT_W;

    typedef struct packed {
        logic [PERIOD_W-1:0] pc;
        logic [PERIOD_W-1:0] per;
        logic [PERIOD_W-1:0] thr;
        logic                on;
        logic                run;
    } core_t;

    core_t st_d, st_q;

    logic [PERIOD_W-1:0] per_new;
    logic [PROD_W-1:0]   prod;
    logic [PERIOD_W-1:0] thr_new;
    logic                wrap;

    always_comb begin
        per_new = (period_i == '0) ? PERIOD_W'(1) : period_i;
        prod    = PROD_W'(duty_i) * PROD_W'(per_new);
        thr_new = PERIOD_W'(prod / PROD_W'(PCT_FULL));
        wrap    = (st_q.pc == st_q.per - 1'b1);

        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (!st_q.run || wrap) begin
            st_d.run = 1'b1;
            st_d.pc  = '0;
            st_d.per = per_new;
            st_d.thr = thr_new;
            st_d.on  = (thr_new != '0);
        end else begin
            st_d.pc = st_q.pc + 1'b1;
            st_d.on = (st_d.pc < st_q.thr);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.on;

endmodule

// File: rtl/bl_dim_ctrl.sv
module bl_dim_ctrl
    import bl_dim_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SETTLE_MS = 500,
    parameter int unsigned PERIOD_W  = 24
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                drv_en_i,
    input  logic [PCT_W-1:0]    duty_req_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                pwm_o,
    output logic                low_unlock_o
);
    localparam int unsigned SETTLE_CYC = (CLK_HZ / 1000) * SETTLE_MS;

    logic open_q;
    pct_t duty_eff;
    logic pwm_q;

    bl_settle_timer #(
        .SETTLE_CYC(SETTLE_CYC)
    ) i_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (drv_en_i),
        .open_o(open_q)
    );

    bl_duty_clamp i_clamp (
        .req_i (duty_req_i),
        .open_i(open_q),
        .eff_o (duty_eff)
    );

    bl_pwm_core #(
        .PERIOD_W(PERIOD_W)
    ) i_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (drv_en_i),
        .duty_i  (duty_eff),
        .period_i(period_i),
        .pwm_o   (pwm_q)
    );

    assign pwm_o        = pwm_q & drv_en_i;
    assign low_unlock_o = open_q & drv_en_i;

endmodule

// File: rtl/bl_dim_ctrl_chk.sv
module bl_dim_ctrl_chk #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SETTLE_MS = 500
) (
    input logic clk_i,
    input logic rst_ni,
    input logic drv_en_i,
    input logic pwm_o,
    input logic low_unlock_o
);
    localparam int unsigned SETTLE_CYC = (CLK_HZ / 1000) * SETTLE_MS;

    logic [31:0] en_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_cnt <= '0;
        end else if (!drv_en_i) begin
            en_cnt <= '0;
        end else if (en_cnt < 32'(SETTLE_CYC)) begin
            en_cnt <= en_cnt + 32'd1;
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_en_i |-> !pwm_o); // R1

    AST_FLAG_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_en_i |-> !low_unlock_o); // R5

    AST_FLAG_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_unlock_o |-> (en_cnt >= 32'(SETTLE_CYC))); // R3

    AST_FLAG_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_i && en_cnt >= 32'(SETTLE_CYC)) |-> low_unlock_o); // R3

    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_i && $past(drv_en_i) && $past(low_unlock_o)) |-> low_unlock_o); // R3

endmodule

bind bl_dim_ctrl bl_dim_ctrl_chk #(
    .CLK_HZ   (CLK_HZ),
    .SETTLE_MS(SETTLE_MS)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drv_en_i    (drv_en_i),
    .pwm_o       (pwm_o),
    .low_unlock_o(low_unlock_o)
);

// File: tb/test_bl_dim_ctrl.sv
module test_bl_dim_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PW         = 16;
    localparam int NSET       = 1000; // 2000 Hz * 500 ms

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [6:0]    duty = '0;
    logic [PW-1:0] per = 16'd100;
    logic          pwm;
    logic          unl;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_dim_ctrl #(
        .CLK_HZ(2000), .SETTLE_MS(500), .PERIOD_W(PW)
    ) i_bl_dim_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .drv_en_i(en), .duty_req_i(duty),
        .period_i(per), .pwm_o(pwm), .low_unlock_o(unl)
    );

    // {duty, period, expected high cycles in first (locked) period}
    localparam logic [39:0] VEC [8] = '{
        {8'd50,  16'd100, 16'd50},
        {8'd0,   16'd100, 16'd5},
        {8'd3,   16'd200, 16'd10},
        {8'd100, 16'd40,  16'd40},
        {8'd127, 16'd40,  16'd40},
        {8'd25,  16'd80,  16'd20},
        {8'd33,  16'd10,  16'd3},
        {8'd1,   16'd100, 16'd5}
    };

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_hi(input int n, output int hi);
        hi = 0;
        for (int j = 0; j < n; j++) begin
            tick();
            hi += int'(pwm);
        end
    endtask

    task automatic restart(input logic [6:0] d, input logic [PW-1:0] p);
        en = 1'b0;
        duty = d;
        per = p;
        tick();
        en = 1'b1;
    endtask

    initial begin
        int hi;
        int j;
        #1;
        check("R1 reset pwm", int'(pwm), 0);
        check("R1 reset flag", int'(unl), 0);
        tick(); tick();
        rst_n = 1'b1;
        duty = 7'd100;
        count_hi(30, hi);
        check("R1 idle with enable low", hi, 0);

        // table walk: R2, R4 floor 5, R8 saturation
        for (int v = 0; v < 8; v++) begin
            restart(VEC[v][38:32], VEC[v][31:16]);
            count_hi(int'(VEC[v][31:16]), hi);
            check($sformatf("R2/R4/R8 vec %0d period 1", v), hi, int'(VEC[v][15:0]));
            count_hi(int'(VEC[v][31:16]), hi);
            check($sformatf("R2 vec %0d period 2", v), hi, int'(VEC[v][15:0]));
        end

        // R3 unlock timing, R4 floor drop
        restart(7'd0, 16'd100);
        count_hi(100, hi);
        check("R4 floor 5 before unlock", hi, 5);
        j = 100;
        while (j < NSET - 1) begin tick(); j++; end
        check("R3 flag low one edge early", int'(unl), 0);
        tick(); j++;
        check("R3 flag high after window", int'(unl), 1);
        count_hi(100, hi);
        check("R4 floor 1 after unlock", hi, 1);
        duty = 7'd100;
        tick();
        check("R2 full on", int'(pwm), 1);
        // R5 immediate drop
        en = 1'b0;
        #1;
        check("R5 pwm drops at once", int'(pwm), 0);
        check("R5 flag drops at once", int'(unl), 0);
        count_hi(5, hi);
        check("R1 stays low", hi, 0);
        duty = 7'd0;
        en = 1'b1;
        count_hi(100, hi);
        check("R5 window restarts with floor 5", hi, 5);
        check("R5 flag still low", int'(unl), 0);

        // R6 duty change mid-period
        restart(7'd20, 16'd100);
        count_hi(10, hi);
        duty = 7'd80;
        begin int h2; count_hi(90, h2); hi += h2; end
        check("R6 old duty kept in period", hi, 20);
        count_hi(100, hi);
        check("R6 new duty at boundary", hi, 80);

        // R7 period change mid-period and zero period
        restart(7'd50, 16'd50);
        count_hi(10, hi);
        per = 16'd20;
        begin int h2; count_hi(40, h2); hi += h2; end
        check("R7 old period kept", hi, 25);
        count_hi(20, hi);
        check("R7 new period first", hi, 10);
        count_hi(20, hi);
        check("R7 new period second", hi, 10);
        restart(7'd100, 16'd0);
        count_hi(10, hi);
        check("R7 zero period as 1 full duty", hi, 10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule